// File: doc/BRIEF.md
# Two-Input Lossless Stream Merger

The block joins two valid-qualified word streams into one. Each cycle, either input may offer a word. Every offered word is written into an internal circular buffer. The buffer head is shown on the single output pair. Words leave in the cycle order in which they arrived. When both inputs offer a word in the same cycle, the word from input A always goes ahead of the word from input B. The output has no ready signal, so it drains one word per clock whenever the buffer holds anything.

A collision puts two words into the buffer but takes only one out. A run of collisions therefore makes the buffer grow. Its depth is set at build time as a power of two. If a clock edge would push the buffer past that depth, the word that does not fit is lost. A sticky flag records the loss and stays set until reset. An occupancy count is also provided as a status output.

At every clock edge the head word is removed first, if there is one. The arrivals of that cycle are then appended at the tail. A word therefore never reaches the output in the cycle in which it is offered.

Top module: `stream_merge2`

## Requirements
- R1: While reset is held and right after its release, `out_valid` is 0, `occupancy` is 0 and `overflow` is 0, whatever was stored before.
- R2: `out_valid` is 1 exactly when `occupancy` is non-zero. While it is 1, `out_data` holds the oldest stored word.
- R3: A cycle with only one valid input appends only that word. A cycle with neither input valid appends nothing.
- R4: A cycle with both inputs valid appends the A word and then the B word, so A leaves one cycle before B.
- R5: Words leave in the order of their arrival cycles, and no word is repeated.
- R6: A word offered into an empty buffer is not visible in the cycle it is offered. It appears on the output in the next cycle.
- R7: While the buffer is non-empty, exactly one word is removed at each clock edge, so a steady single-input stream passes through with occupancy 1.
- R8: After each edge, `occupancy` equals the previous count, minus 1 if it was non-zero, plus the number of words appended (never above DEPTH = 2^AW).
- R9: If both inputs are valid while `occupancy` equals DEPTH, the A word is stored and the B word is dropped. `overflow` goes to 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_valid | input | 1 | Input A offers a word this cycle |
| a_data | input | W | Input A word |
| b_valid | input | 1 | Input B offers a word this cycle |
| b_data | input | W | Input B word |
| out_valid | output | 1 | Output word present |
| out_data | output | W | Oldest stored word |
| occupancy | output | AW+1 | Number of words stored |
| overflow | output | 1 | Sticky: a word has been dropped |

## Verification
The checker assumes that the valid inputs are never unknown once reset is released. It also assumes that a data input is only relevant in cycles where its valid is high, so the ordering properties compare data only after such cycles. The bench drives every input at the falling edge to a defined value, and it zeroes the data of an idle input. The table deliberately fills the buffer to DEPTH and then collides once more, so the drop path and the sticky flag are both reached.

// File: rtl/stream_merge2.sv
module stream_merge2 #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_valid,
  input  logic [W-1:0]  a_data,
  input  logic          b_valid,
  input  logic [W-1:0]  b_data,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [AW:0]   occupancy,
  output logic          overflow
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic          ovf_q;

  logic          pop;
  logic [CW-1:0] base;
  logic          put_b;
  logic [AW-1:0] tail;
  logic [AW-1:0] slot_b;

  assign pop    = count != '0;
  assign base   = count - CW'(pop);
  assign put_b  = b_valid && ((base + CW'(a_valid)) < CW'(DEPTH));
  assign tail   = rd_ptr + count[AW-1:0];
  assign slot_b = tail + AW'(a_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      count  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      rd_ptr <= rd_ptr + AW'(pop);
      count  <= base + CW'(a_valid) + CW'(put_b);
      ovf_q  <= ovf_q | (b_valid & ~put_b);
    end
  end

  always_ff @(posedge clk) begin
    if (a_valid) mem[tail]   <= a_data;
    if (put_b)   mem[slot_b] <= b_data;
  end

  assign out_valid = pop;
  assign out_data  = mem[rd_ptr];
  assign occupancy = count;
  assign overflow  = ovf_q;
endmodule

// File: rtl/stream_merge2_chk.sv
module stream_merge2_chk #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_valid,
  input logic [W-1:0]  a_data,
  input logic          b_valid,
  input logic [W-1:0]  b_data,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic [AW:0]   occupancy,
  input logic          overflow
);
  localparam logic [AW:0] FULL = (AW+1)'(1 << AW);

  p_absent_when_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0) |-> !out_valid);

  p_single_enqueue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0 && a_valid && !b_valid)
      |=> (out_valid && out_data == $past(a_data) && occupancy == 1));

  p_a_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0 && a_valid && b_valid)
      |=> (out_valid && out_data == $past(a_data) && occupancy == 2));

  p_b_follows_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0 && a_valid && b_valid) ##1 (!a_valid && !b_valid)
      |=> (out_valid && out_data == $past(b_data, 2)));

  p_not_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0) |-> !out_valid);

  p_idle_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_valid && !b_valid && occupancy != '0)
      |=> (occupancy == $past(occupancy) - 1'b1));

  p_occ_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= FULL);

  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && b_valid && occupancy == FULL) |=> overflow);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(a_valid && b_valid && occupancy == FULL));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind stream_merge2 stream_merge2_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_valid(a_valid), .a_data(a_data),
  .b_valid(b_valid), .b_data(b_data),
  .out_valid(out_valid), .out_data(out_data),
  .occupancy(occupancy), .overflow(overflow)
);

// File: tb/stream_merge2_bench.sv
module stream_merge2_bench;
  localparam int W  = 8;
  localparam int AW = 2;
  localparam int N  = 12;

  // stimulus row: {a_valid, a_data, b_valid, b_data}
  localparam logic [17:0] STIM [N] = '{
    {1'b1, 8'h11, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 8'h00},
    {1'b1, 8'h21, 1'b1, 8'h22},
    {1'b0, 8'h00, 1'b1, 8'h31},
    {1'b1, 8'h41, 1'b1, 8'h42},
    {1'b1, 8'h51, 1'b1, 8'h52},
    {1'b1, 8'h61, 1'b0, 8'h00},
    {1'b1, 8'h71, 1'b1, 8'h72},
    {1'b0, 8'h00, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 8'h00}
  };
  // expected after the edge: {out_valid, out_data (0 if absent), occupancy, overflow}
  localparam logic [12:0] EXP [N] = '{
    {1'b1, 8'h11, 3'd1, 1'b0},
    {1'b0, 8'h00, 3'd0, 1'b0},
    {1'b1, 8'h21, 3'd2, 1'b0},
    {1'b1, 8'h22, 3'd2, 1'b0},
    {1'b1, 8'h31, 3'd3, 1'b0},
    {1'b1, 8'h41, 3'd4, 1'b0},
    {1'b1, 8'h42, 3'd4, 1'b0},
    {1'b1, 8'h51, 3'd4, 1'b1},
    {1'b1, 8'h52, 3'd3, 1'b1},
    {1'b1, 8'h61, 3'd2, 1'b1},
    {1'b1, 8'h71, 3'd1, 1'b1},
    {1'b0, 8'h00, 3'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_valid = 1'b0, b_valid = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic out_valid, overflow;
  logic [W-1:0] out_data;
  logic [AW:0] occupancy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  stream_merge2 #(.W(W), .AW(AW)) u_stream_merge2 (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_data(a_data),
    .b_valid(b_valid), .b_data(b_data),
    .out_valid(out_valid), .out_data(out_data),
    .occupancy(occupancy), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] snap();
    return {out_valid, out_valid ? out_data : 8'h00, occupancy, overflow};
  endfunction

  task automatic drive(input logic av, input logic [W-1:0] ad, input logic bv, input logic [W-1:0] bd);
    a_valid = av; a_data = ad; b_valid = bv; b_data = bd;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    step();
    chk(snap() == 13'h0, "R1 state in reset", 32'(snap()), 32'h0);
    rst_n = 1'b1;
    step();
    chk(snap() == 13'h0, "R1 state after release", 32'(snap()), 32'h0);

    // table: R2/R3/R4/R5/R8/R9
    for (int i = 0; i < N; i++) begin
      drive(STIM[i][17], STIM[i][16:9], STIM[i][8], STIM[i][7:0]);
      step();
      chk(snap() == EXP[i], $sformatf("R2/R3/R4/R5/R8/R9 row %0d", i), 32'(snap()), 32'(EXP[i]));
    end

    // R1: reset mid-stream clears stored words and the sticky flag
    drive(1'b1, 8'hA1, 1'b1, 8'hA2);
    step();
    drive(1'b0, 8'h00, 1'b0, 8'h00);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    chk(snap() == 13'h0, "R1 mid-stream reset", 32'(snap()), 32'h0);

    // R6: not visible in the offering cycle, visible in the next
    drive(1'b0, 8'h00, 1'b1, 8'h5A);
    #1;
    chk(out_valid == 1'b0, "R6 same-cycle output", 32'(out_valid), 32'h0);
    step();
    drive(1'b0, 8'h00, 1'b0, 8'h00);
    chk(out_valid && out_data == 8'h5A, "R6 next-cycle output", 32'({out_valid, out_data}), 32'h15A);
    step();
    chk(!out_valid && occupancy == 0, "R3 idle appends nothing", 32'(occupancy), 32'h0);

    // R7: steady A stream passes with occupancy 1
    for (int k = 1; k <= 16; k++) begin
      drive(1'b1, W'(k * 3), 1'b0, 8'h00);
      step();
      chk(out_valid && out_data == W'(k * 3) && occupancy == 1,
          $sformatf("R7 stream beat %0d", k),
          32'({out_valid, out_data, occupancy}), 32'({1'b1, W'(k * 3), 3'd1}));
    end
    drive(1'b0, 8'h00, 1'b0, 8'h00);
    step();
    chk(occupancy == 0 && !overflow, "R8 drained, no overflow", 32'({occupancy, overflow}), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule